// File: doc/BRIEF.md
# Condition-Code Mask Branch Unit

This block resolves a conditional branch for a processor whose status word carries a two-bit condition code. Each cycle it may receive one 32-bit register-indexed instruction word, together with the current condition code, the address of that instruction and the contents of the two registers named by the instruction. The block decodes the index and base register numbers and presents them on its outputs, so that a neighbouring register file can supply their values in the same cycle.

When the opcode is the branch-on-condition code, the block adds the two register values to the displacement to form a target address. It picks the mask bit that belongs to the current condition code and registers two results: a taken flag, and the next instruction address. The next address is the target when the branch is taken and the sequential address otherwise. Any other opcode falls through without a branch.

Top module: `bcu_branch_unit`

## Requirements
- R1: While reset is asserted, and until the first valid strobe after it, `out_valid`, `taken` and `next_addr` are all 0.
- R2: Instruction fields sit at fixed bit positions: opcode in bits 31:24, mask in 23:20, index register number in 19:16, base register number in 15:12 and displacement in 11:0. The condition code is encoded 0 = zero/equal, 1 = low/minus, 2 = high/plus, 3 = overflow. A valid branch-on-condition instruction is taken exactly when mask bit (3 − cc) is 1, so mask bit 3 stands for zero/equal and bit 0 for overflow.
- R3: When a branch is taken, `next_addr` equals index value + base value + zero-extended displacement, wrapped modulo 2^AW.
- R4: When a valid instruction is not taken, `next_addr` equals `cur_addr` + 4, wrapped modulo 2^AW.
- R5: An index or base register number of 0 contributes zero to the target, whatever value is on `idx_val` or `base_val`.
- R6: Mask 0 never branches, whatever the condition code. Mask 15 always branches.
- R7: A valid instruction whose opcode differs from OPCODE (default 8'h47) gives `taken` = 0 and `next_addr` = `cur_addr` + 4.
- R8: Results appear one clock after the valid strobe, with `out_valid` high for exactly that cycle. In a cycle where `in_valid` is low, `next_addr` and `taken` keep their values and `out_valid` is low in the following cycle.
- R9: `idx_sel` and `base_sel` show the index and base register numbers of `instr` in the same cycle, without a register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| cc | input | 2 | Current condition code |
| cur_addr | input | AW | Address of the instruction |
| idx_val | input | AW | Contents of the index register |
| base_val | input | AW | Contents of the base register |
| idx_sel | output | 4 | Index register number to read |
| base_sel | output | 4 | Base register number to read |
| next_addr | output | AW | Registered next instruction address |
| taken | output | 1 | Registered branch-taken flag |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |

## Verification
The properties assume that `idx_val` and `base_val` already hold the registers named by `idx_sel` and `base_sel` in the same cycle as the strobe. They also assume that `instr`, `cc` and `cur_addr` are stable around the sampling edge. The bench drives every input at the falling edge and supplies the register values together with the instruction word, so both assumptions hold. The register values it picks are arbitrary, which lets the zero-field cases show that those values are ignored.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int OP_W   = 8;
  localparam int MASK_W = 4;
  localparam int RSEL_W = 4;
  localparam int DISP_W = 12;
  localparam int INSTR_W = OP_W + MASK_W + 2 * RSEL_W + DISP_W;

  // Register-indexed instruction word, most significant field first.
  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [MASK_W-1:0] mask;
    logic [RSEL_W-1:0] xsel;
    logic [RSEL_W-1:0] bsel;
    logic [DISP_W-1:0] disp;
  } bcu_word_t;
endpackage

// File: rtl/bcu_target.sv
// Effective address adder: index + base + displacement, with a register
// number of zero standing for a zero term.
module bcu_target #(
  parameter int AW = 32
) (
  input  logic [bcu_pkg::RSEL_W-1:0] xsel,
  input  logic [bcu_pkg::RSEL_W-1:0] bsel,
  input  logic [AW-1:0]              xval,
  input  logic [AW-1:0]              bval,
  input  logic [bcu_pkg::DISP_W-1:0] disp,
  output logic [AW-1:0]              target
);
  logic [AW-1:0] xterm;
  logic [AW-1:0] bterm;
  logic [AW-1:0] dterm;

  always_comb begin
    xterm  = (xsel == '0) ? '0 : xval;
    bterm  = (bsel == '0) ? '0 : bval;
    dterm  = AW'(disp);
    target = xterm + bterm + dterm;
  end
endmodule

// File: rtl/bcu_cond.sv
// Mask selection: condition code value g enables mask bit (NCOND-1-g).
module bcu_cond #(
  parameter int CC_W = 2
) (
  input  logic [CC_W-1:0]        cc,
  input  logic [(1<<CC_W)-1:0]   mask,
  output logic                   hit
);
  localparam int NCOND = 1 << CC_W;

  logic [NCOND-1:0] sel;

  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    assign sel[g] = (cc == CC_W'(g)) & mask[NCOND-1-g];
  end

  assign hit = |sel;
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit #(
  parameter int          AW     = 32,
  parameter logic [7:0]  OPCODE = 8'h47,
  parameter int          ILEN   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [bcu_pkg::INSTR_W-1:0]   instr,
  input  logic [1:0]                    cc,
  input  logic [AW-1:0]                 cur_addr,
  input  logic [AW-1:0]                 idx_val,
  input  logic [AW-1:0]                 base_val,
  output logic [bcu_pkg::RSEL_W-1:0]    idx_sel,
  output logic [bcu_pkg::RSEL_W-1:0]    base_sel,
  output logic [AW-1:0]                 next_addr,
  output logic                          taken,
  output logic                          out_valid
);
  import bcu_pkg::*;

  localparam int CC_W = 2;

  bcu_word_t     word;
  logic          is_bc;
  logic          hit;
  logic [AW-1:0] target;
  logic [AW-1:0] fall;
  logic [AW-1:0] addr_d;
  logic          taken_d;
  logic          load_en;

  assign word     = bcu_word_t'(instr);
  assign idx_sel  = word.xsel;
  assign base_sel = word.bsel;

  bcu_target #(.AW(AW)) u_target (
    .xsel   (word.xsel),
    .bsel   (word.bsel),
    .xval   (idx_val),
    .bval   (base_val),
    .disp   (word.disp),
    .target (target)
  );

  bcu_cond #(.CC_W(CC_W)) u_cond (
    .cc   (cc),
    .mask (word.mask),
    .hit  (hit)
  );

  // Next-state logic
  always_comb begin
    load_en = in_valid;
    is_bc   = (word.op == OPCODE);
    fall    = cur_addr + AW'(ILEN);
    taken_d = is_bc & hit;
    addr_d  = taken_d ? target : fall;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_addr <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) begin
        taken     <= taken_d;
        next_addr <= addr_d;
      end
    end
  end
endmodule

// File: rtl/bcu_checks.sv
module bcu_checks #(
  parameter int          AW     = 32,
  parameter logic [7:0]  OPCODE = 8'h47,
  parameter int          ILEN   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   instr,
  input logic [1:0]    cc,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] idx_val,
  input logic [AW-1:0] base_val,
  input logic [3:0]    idx_sel,
  input logic [3:0]    base_sel,
  input logic [AW-1:0] next_addr,
  input logic          taken,
  input logic          out_valid
);
  logic [3:0]    m;
  logic          want;
  logic          op_ok;
  logic [AW-1:0] exp_tgt;

  always_comb begin
    m       = instr[23:20];
    want    = m[~cc];
    op_ok   = (instr[31:24] == OPCODE);
    exp_tgt = ((instr[19:16] == 4'd0) ? '0 : idx_val)
            + ((instr[15:12] == 4'd0) ? '0 : base_val)
            + AW'(instr[11:0]);
  end

  a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(next_addr) && $stable(taken)));
  a_r2_select: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok) |=> (taken == $past(want)));
  a_r6_never: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && m == 4'd0) |=> !taken);
  a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && m == 4'hF) |=> taken);
  a_r7_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_ok) |=> (!taken && next_addr == $past(cur_addr) + AW'(ILEN)));
  a_r3_target: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_ok && want) |=> (next_addr == $past(exp_tgt)));
  a_r4_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(op_ok && want)) |=> (next_addr == $past(cur_addr) + AW'(ILEN)));
  a_r9_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_sel == instr[19:16] && base_sel == instr[15:12]));
endmodule

bind bcu_branch_unit bcu_checks #(.AW(AW), .OPCODE(OPCODE), .ILEN(ILEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .cc(cc),
  .cur_addr(cur_addr), .idx_val(idx_val), .base_val(base_val),
  .idx_sel(idx_sel), .base_sel(base_sel), .next_addr(next_addr),
  .taken(taken), .out_valid(out_valid)
);

// File: tb/sim_bcu_branch_unit.sv
module sim_bcu_branch_unit;
  localparam int AW = 32;
  localparam int NV = 17;
  localparam int VW = 163;

  // {instr, cc, cur_addr, idx_val, base_val, exp_taken, exp_next}
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h47812010, 2'd0, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002110}, // R2 zero/equal
    {32'h47812010, 2'd1, 32'h00001000, 32'h00000100, 32'h00002000, 1'b0, 32'h00001004}, // R2 R4
    {32'h47712010, 2'd3, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002110}, // R2 mask 7
    {32'h47712010, 2'd0, 32'h00001000, 32'h00000100, 32'h00002000, 1'b0, 32'h00001004}, // R2 mask 7 eq
    {32'h47012010, 2'd2, 32'h00001000, 32'h00000100, 32'h00002000, 1'b0, 32'h00001004}, // R6 mask 0
    {32'h47F12010, 2'd1, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002110}, // R6 mask 15
    {32'h47212010, 2'd2, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002110}, // R2 high
    {32'h47212010, 2'd1, 32'h00001000, 32'h00000100, 32'h00002000, 1'b0, 32'h00001004}, // R2 high vs low
    {32'h47412010, 2'd1, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002110}, // R2 low
    {32'h47112010, 2'd3, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002110}, // R2 overflow
    {32'h47F02010, 2'd0, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00002010}, // R5 index 0
    {32'h47F10010, 2'd0, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00000110}, // R5 base 0
    {32'h47F00ABC, 2'd2, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h00000ABC}, // R5 both 0
    {32'h47F12000, 2'd3, 32'h00001000, 32'hFFFFFFF0, 32'h00000020, 1'b1, 32'h00000010}, // R3 wrap
    {32'h47012010, 2'd0, 32'hFFFFFFFC, 32'h00000100, 32'h00002000, 1'b0, 32'h00000000}, // R4 wrap
    {32'h07F12010, 2'd0, 32'h00001000, 32'h00000100, 32'h00002000, 1'b0, 32'h00001004}, // R7 foreign
    {32'h47F12FFF, 2'd0, 32'h00001000, 32'h00000100, 32'h00002000, 1'b1, 32'h000030FF}  // R3 max disp
  };

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [31:0]   instr;
  logic [1:0]    cc;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] idx_val;
  logic [AW-1:0] base_val;
  logic [3:0]    idx_sel;
  logic [3:0]    base_sel;
  logic [AW-1:0] next_addr;
  logic          taken;
  logic          out_valid;

  int n_run;
  int n_fail;

  bcu_branch_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .cc(cc),
    .cur_addr(cur_addr), .idx_val(idx_val), .base_val(base_val),
    .idx_sel(idx_sel), .base_sel(base_sel), .next_addr(next_addr),
    .taken(taken), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; cc = '0;
    cur_addr = '0; idx_val = '0; base_val = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(taken == 1'b0, "R1 taken", 64'(taken), 64'd0);
    check(next_addr == '0, "R1 next_addr", 64'(next_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && next_addr == '0, "R1 after release",
          64'(next_addr), 64'd0);

    for (int i = 0; i < NV; i++) begin
      instr    = VEC[i][162:131];
      cc       = VEC[i][130:129];
      cur_addr = VEC[i][128:97];
      idx_val  = VEC[i][96:65];
      base_val = VEC[i][64:33];
      in_valid = 1'b1;
      @(negedge clk);
      check(taken == VEC[i][32], $sformatf("R2 R6 R7 taken vec %0d", i),
            64'(taken), 64'(VEC[i][32]));
      check(next_addr == VEC[i][31:0], $sformatf("R3 R4 R5 next_addr vec %0d", i),
            64'(next_addr), 64'(VEC[i][31:0]));
      check(out_valid == 1'b1, $sformatf("R8 out_valid vec %0d", i),
            64'(out_valid), 64'd1);
    end

    // R8: idle cycle holds results, inputs that would change them are ignored
    in_valid = 1'b0;
    instr    = 32'h47F00ABC;
    cc       = 2'd0;
    cur_addr = 32'h00005000;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 idle out_valid", 64'(out_valid), 64'd0);
    check(next_addr == 32'h000030FF, "R8 idle hold next_addr",
          64'(next_addr), 64'h30FF);
    check(taken == 1'b1, "R8 idle hold taken", 64'(taken), 64'd1);

    // R8: single strobe then idle, taken falls back to not-taken value
    instr = 32'h47012010; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(taken == 1'b0 && next_addr == 32'h00005004, "R8 strobe result",
          64'(next_addr), 64'h5004);
    @(negedge clk);
    check(out_valid == 1'b0, "R8 strobe width", 64'(out_valid), 64'd0);

    // R9: register numbers decoded without a clock
    instr = 32'h4712A000;
    #1;
    check(idx_sel == 4'h2, "R9 idx_sel", 64'(idx_sel), 64'h2);
    check(base_sel == 4'hA, "R9 base_sel", 64'(base_sel), 64'hA);

    // R1: reset in mid-run clears results
    rst_n = 1'b0;
    #1;
    check(next_addr == '0 && taken == 1'b0, "R1 async reset",
          64'(next_addr), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule